// File: doc/BRIEF.md
# Microprogram Address Sequencer with One-Deep Return

This block produces the microcode ROM address for a microcoded 8-bit processor. Each cycle it looks at the control fields of the microinstruction now being executed, which the ROM presents at its inputs. From those fields it picks the next address. That address is one of the following: the current address plus one, the fetch entry, the halt entry, a subroutine target, the address saved in its single return register, or the entry address supplied by an external opcode decoder.

Reset parks the address at the reset entry. The word stored there is never acted on: in the first cycle after reset the sequencer steps past it whatever the fields say. A subroutine call keeps exactly one return address, so a call made inside a subroutine replaces it. A conditional call tests one of eight flag conditions. When the condition holds it acts as a call; when it fails it finishes the instruction and goes back to fetch. While an interrupt is being acknowledged, the block raises a signal that tells the program-counter logic not to advance while the fetch routine is running.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset sets `uaddr` to 0. In the first cycle after reset is released the next address is 1, and every control field is ignored.
- R2: With `mi_end` set, the next address is the fetch entry 3.
- R3: With `mi_halt` and `mi_end` set together, the next address is 7 and the return register keeps its value. A later return still goes to the address saved earlier.
- R4: With `mi_call` set, the next address is `mi_target` and the return register is loaded with `uaddr + 1`. With `mi_ret` set, the next address is the value in the return register.
- R5: With `mi_ccall` set and the selected condition true, it acts as R4's call. With the condition false, the next address is 3 and the return register is unchanged.
- R6: `mi_cond_sel` picks a condition as follows: 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 P clear (parity odd), 5 P set, 6 S clear (plus), 7 S set (minus).
- R7: With `mi_decode` set, the next address is `dec_entry`.
- R8: With no control field set, the next address is `uaddr + 1` modulo 256, so address 255 is followed by 0.
- R9: A call made while a return address is already held overwrites it. Only the newest return address survives.
- R10: `pc_inc_block` is 1 exactly when `int_ack` is 1 and `uaddr` lies in the fetch routine, addresses 3 to 6.
- R11: When several fields are set, the order of precedence is halt, then end, then return, then call or conditional call, then decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mi_end | input | 1 | Finish instruction, go to fetch |
| mi_halt | input | 1 | Go to halt entry (given with mi_end) |
| mi_ret | input | 1 | Return to saved address |
| mi_call | input | 1 | Unconditional subroutine call |
| mi_ccall | input | 1 | Conditional call, else finish instruction |
| mi_decode | input | 1 | Jump to decoder entry address |
| mi_cond_sel | input | 3 | Condition select for mi_ccall |
| mi_target | input | 8 | Subroutine target address |
| dec_entry | input | 8 | Entry address from the opcode decoder |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| flag_s | input | 1 | Sign flag |
| int_ack | input | 1 | Interrupt acknowledge in progress |
| uaddr | output | 8 | Current microcode address |
| pc_inc_block | output | 1 | Inhibit program-counter increment |

## Verification
The bench builds the block with its default 8-bit address and the entry points 0, 3 and 7. At this width it can sweep every one of the 256 decoder entry values and test the wrap from 255 to 0. Every pairing of the eight condition codes with all sixteen flag combinations is tried as a conditional call, and each one is followed by a return. That return shows whether the return register was loaded or left alone.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    CC_ZCLR = 3'd0,
    CC_ZSET = 3'd1,
    CC_CCLR = 3'd2,
    CC_CSET = 3'd3,
    CC_ODD  = 3'd4,
    CC_EVEN = 3'd5,
    CC_PLUS = 3'd6,
    CC_MINUS = 3'd7
  } cc_e;

  typedef enum logic [2:0] {
    SRC_STEP,
    SRC_FETCH,
    SRC_HALT,
    SRC_LINK,
    SRC_TARGET,
    SRC_DECODE
  } src_e;

endpackage

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       fz,
  input  logic       fc,
  input  logic       fp,
  input  logic       fs,
  output logic       hit
);
  always_comb begin
    case (cc_e'(sel))
      CC_ZCLR:  hit = ~fz;
      CC_ZSET:  hit = fz;
      CC_CCLR:  hit = ~fc;
      CC_CSET:  hit = fc;
      CC_ODD:   hit = ~fp;
      CC_EVEN:  hit = fp;
      CC_PLUS:  hit = ~fs;
      default:  hit = fs;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int FETCH_VEC = 3,
  parameter int HALT_VEC  = 7
) (
  input  logic          primed,
  input  logic          f_end,
  input  logic          f_halt,
  input  logic          f_ret,
  input  logic          f_call,
  input  logic          f_ccall,
  input  logic          f_decode,
  input  logic          cc_hit,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] link,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] entry,
  output logic [AW-1:0] nxt,
  output logic          save_link
);
  localparam logic [AW-1:0] FETCH_A = AW'(FETCH_VEC);
  localparam logic [AW-1:0] HALT_A  = AW'(HALT_VEC);

  src_e src;

  always_comb begin
    src       = SRC_STEP;
    save_link = 1'b0;
    if (primed) begin
      if (f_halt)                     src = SRC_HALT;
      else if (f_end)                 src = SRC_FETCH;
      else if (f_ret)                 src = SRC_LINK;
      else if (f_call || (f_ccall && cc_hit)) begin
        src       = SRC_TARGET;
        save_link = 1'b1;
      end
      else if (f_ccall)               src = SRC_FETCH;
      else if (f_decode)              src = SRC_DECODE;
    end
  end

  always_comb begin
    case (src)
      SRC_FETCH:  nxt = FETCH_A;
      SRC_HALT:   nxt = HALT_A;
      SRC_LINK:   nxt = link;
      SRC_TARGET: nxt = target;
      SRC_DECODE: nxt = entry;
      default:    nxt = cur + 1'b1;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int AW        = 8,
  parameter int RESET_VEC = 0,
  parameter int FETCH_VEC = 3,
  parameter int HALT_VEC  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mi_end,
  input  logic          mi_halt,
  input  logic          mi_ret,
  input  logic          mi_call,
  input  logic          mi_ccall,
  input  logic          mi_decode,
  input  logic [2:0]    mi_cond_sel,
  input  logic [AW-1:0] mi_target,
  input  logic [AW-1:0] dec_entry,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_p,
  input  logic          flag_s,
  input  logic          int_ack,
  output logic [AW-1:0] uaddr,
  output logic          pc_inc_block
);
  localparam logic [AW-1:0] RESET_A = AW'(RESET_VEC);
  localparam logic [AW-1:0] FETCH_A = AW'(FETCH_VEC);
  localparam logic [AW-1:0] HALT_A  = AW'(HALT_VEC);

  logic [AW-1:0] uaddr_q, link_q, nxt;
  logic          primed_q, cc_hit, save_link;

  useq_cond u_cond (
    .sel (mi_cond_sel),
    .fz  (flag_z),
    .fc  (flag_c),
    .fp  (flag_p),
    .fs  (flag_s),
    .hit (cc_hit)
  );

  useq_next #(
    .AW        (AW),
    .FETCH_VEC (FETCH_VEC),
    .HALT_VEC  (HALT_VEC)
  ) u_next (
    .primed    (primed_q),
    .f_end     (mi_end),
    .f_halt    (mi_halt),
    .f_ret     (mi_ret),
    .f_call    (mi_call),
    .f_ccall   (mi_ccall),
    .f_decode  (mi_decode),
    .cc_hit    (cc_hit),
    .cur       (uaddr_q),
    .link      (link_q),
    .target    (mi_target),
    .entry     (dec_entry),
    .nxt       (nxt),
    .save_link (save_link)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr_q  <= RESET_A;
      link_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      uaddr_q  <= nxt;
      primed_q <= 1'b1;
      if (save_link) link_q <= uaddr_q + 1'b1;
    end
  end

  assign uaddr        = uaddr_q;
  assign pc_inc_block = int_ack && (uaddr_q >= FETCH_A) && (uaddr_q < HALT_A);

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int AW        = 8,
  parameter int RESET_VEC = 0,
  parameter int FETCH_VEC = 3,
  parameter int HALT_VEC  = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          mi_end,
  input logic          mi_halt,
  input logic          mi_ret,
  input logic          mi_call,
  input logic          mi_ccall,
  input logic          cc_hit,
  input logic          primed_q,
  input logic [AW-1:0] uaddr,
  input logic [AW-1:0] link_q
);
  logic was_rst;
  logic armed;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    armed   <= 1'b1;
  end

  // R1: the address is at the reset entry right after a reset cycle
  always_ff @(posedge clk) begin
    if (armed && was_rst && !rst)
      p_reset_entry_r1: assert (uaddr == AW'(RESET_VEC))
        else $error("reset entry wrong");
  end

  p_end_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (primed_q && mi_end && !mi_halt) |=> (uaddr == AW'(FETCH_VEC)));

  p_halt_park_r3: assert property (@(posedge clk) disable iff (rst)
    (primed_q && mi_halt) |=> (uaddr == AW'(HALT_VEC)) && $stable(link_q));

  p_return_r4: assert property (@(posedge clk) disable iff (rst)
    (primed_q && mi_ret && !mi_end && !mi_halt) |=> (uaddr == $past(link_q)));

  p_call_save_r4: assert property (@(posedge clk) disable iff (rst)
    (primed_q && mi_call && !mi_ret && !mi_end && !mi_halt)
      |=> (link_q == $past(uaddr) + 1'b1));

  p_ccall_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (primed_q && mi_ccall && !cc_hit && !mi_call && !mi_ret && !mi_halt)
      |=> (uaddr == AW'(FETCH_VEC)) && $stable(link_q));

  p_halt_with_end_r3: assert property (@(posedge clk) disable iff (rst)
    mi_halt |-> mi_end);

endmodule

bind useq_top useq_chk #(
  .AW        (AW),
  .RESET_VEC (RESET_VEC),
  .FETCH_VEC (FETCH_VEC),
  .HALT_VEC  (HALT_VEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mi_end   (mi_end),
  .mi_halt  (mi_halt),
  .mi_ret   (mi_ret),
  .mi_call  (mi_call),
  .mi_ccall (mi_ccall),
  .cc_hit   (cc_hit),
  .primed_q (primed_q),
  .uaddr    (uaddr_q),
  .link_q   (link_q)
);

// File: tb/useq_top_test.sv
module useq_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       mi_end, mi_halt, mi_ret, mi_call, mi_ccall, mi_decode;
  logic [2:0] mi_cond_sel;
  logic [7:0] mi_target, dec_entry;
  logic       flag_z, flag_c, flag_p, flag_s, int_ack;
  logic [7:0] uaddr;
  logic       pc_inc_block;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_link;
  logic [7:0] here;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top uut (
    .clk, .rst, .mi_end, .mi_halt, .mi_ret, .mi_call, .mi_ccall, .mi_decode,
    .mi_cond_sel, .mi_target, .dec_entry, .flag_z, .flag_c, .flag_p, .flag_s,
    .int_ack, .uaddr, .pc_inc_block
  );

  task automatic clear();
    mi_end = 0; mi_halt = 0; mi_ret = 0; mi_call = 0; mi_ccall = 0;
    mi_decode = 0; mi_cond_sel = 0; mi_target = 0; dec_entry = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear();
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_to(input logic [7:0] a);
    mi_decode = 1; dec_entry = a; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    clear();
    flag_z = 0; flag_c = 0; flag_p = 0; flag_s = 0; int_ack = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset address", uaddr, 8'd0);
    rst = 0;
    mi_end = 1; mi_call = 1; mi_target = 8'h55;  // all ignored: R1
    tick();
    chk("R1 first step ignores fields", uaddr, 8'd1);
    tick();
    chk("R8 step", uaddr, 8'd2);
    mi_end = 1; tick();
    chk("R2 end to fetch", uaddr, 8'd3);

    // R10 fetch window
    int_ack = 1; #1;
    chk("R10 block at 3", {7'd0, pc_inc_block}, 8'd1);
    for (int k = 4; k <= 7; k++) begin
      tick();
      chk("R8 step in fetch", uaddr, 8'(k));
      chk("R10 block window", {7'd0, pc_inc_block}, (k < 7) ? 8'd1 : 8'd0);
    end
    mi_end = 1; tick();
    int_ack = 0; #1;
    chk("R10 no ack no block", {7'd0, pc_inc_block}, 8'd0);
    go_to(8'd2); int_ack = 1; #1;
    chk("R10 below fetch", {7'd0, pc_inc_block}, 8'd0);
    int_ack = 0;

    // R7 decode sweep
    for (int v = 0; v < 256; v++) begin
      mi_decode = 1; dec_entry = 8'(v); tick();
      chk("R7 decode entry", uaddr, 8'(v));
    end
    tick();
    chk("R8 wrap 255 to 0", uaddr, 8'd0);

    // R5/R6 conditional call sweep
    exp_link = 8'd0;
    for (int sel = 0; sel < 8; sel++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] fv;
        logic       want;
        fv   = 4'(f);
        go_to(8'(8'h10 + sel));
        here = uaddr;
        {flag_s, flag_p, flag_c, flag_z} = fv;
        want = (fv[sel >> 1] == sel[0]);
        mi_ccall = 1; mi_cond_sel = 3'(sel); mi_target = 8'(8'h80 + f);
        tick();
        if (want) begin
          chk("R6 R5 ccall taken", uaddr, 8'(8'h80 + f));
          exp_link = here + 8'd1;
        end else begin
          chk("R6 R5 ccall not taken", uaddr, 8'd3);
        end
        mi_ret = 1; tick();
        chk("R4 R5 return after ccall", uaddr, exp_link);
      end
    end
    {flag_s, flag_p, flag_c, flag_z} = 4'd0;

    // R4 plain call and R9 nesting
    go_to(8'h40);
    mi_call = 1; mi_target = 8'h60; tick();
    chk("R4 call target", uaddr, 8'h60);
    mi_call = 1; mi_target = 8'h70; tick();
    chk("R9 nested call target", uaddr, 8'h70);
    mi_ret = 1; tick();
    chk("R9 return to newest", uaddr, 8'h61);
    mi_ret = 1; tick();
    chk("R9 older link gone", uaddr, 8'h61);

    // R3 halt with end, link preserved; priority R11
    go_to(8'h22);
    mi_call = 1; mi_target = 8'h90; tick();
    mi_halt = 1; mi_end = 1; mi_call = 1; mi_ret = 1; mi_target = 8'hA0; tick();
    chk("R3 halt entry", uaddr, 8'd7);
    mi_ret = 1; tick();
    chk("R3 link kept over halt", uaddr, 8'h23);

    go_to(8'h30);
    mi_end = 1; mi_ret = 1; mi_call = 1; mi_decode = 1; dec_entry = 8'hCC; tick();
    chk("R11 end beats others", uaddr, 8'd3);
    mi_ret = 1; mi_call = 1; mi_target = 8'hB0; tick();
    chk("R11 return beats call", uaddr, 8'h23);
    mi_call = 1; mi_target = 8'hB0; mi_decode = 1; dec_entry = 8'hCC; tick();
    chk("R11 call beats decode", uaddr, 8'hB0);
    flag_z = 1;
    mi_ccall = 1; mi_cond_sel = 3'd0; mi_decode = 1; dec_entry = 8'hCC; tick();
    chk("R11 R5 failed ccall beats decode", uaddr, 8'd3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule